// File: doc/BRIEF.md
# SECDED Hamming Codec for a 4-bit Nibble

This block guards a 4-bit data nibble with an 8-bit codeword. The codeword can correct any one flipped bit and can detect any two flipped bits. It has two independent channels that share one clock.

The **encode channel** turns a nibble into a codeword. The codeword holds three Hamming check bits at the power-of-two positions, the data bits at the other positions of 1..7, and an overall parity bit at position 8.

The **decode channel** takes a codeword that may have been corrupted in storage or in transit. It recomputes the check bits from the received data bits and XORs them with the received check bits to form the syndrome. It then combines the syndrome with the overall parity result to sort the read into one of three classes:
- clean;
- single error, corrected;
- double error, uncorrectable.

Each channel ends in an output stage. By default this stage is a register, which gives one cycle of latency. A parameter can make it a plain wire instead. A valid bit travels alongside the payload. The number of check bits is a parameter, and the data width and codeword width are derived from it.

Top module: `sec_ded_codec`

## Requirements
- R1: Codeword bit k (0-based) holds position k+1. Check bits sit at bits 0, 1 and 3 (positions 1, 2, 4). Data bits 0..3 sit at bits 2, 4, 5 and 6 (positions 3, 5, 6, 7). The overall parity bit is bit 7.
- R2: Check bit j is the XOR of the data bits whose position has bit j set. For positions 1, 2 and 4 this gives XORs over positions {3,5,7}, {3,6,7} and {5,6,7}.
- R3: The parity bit makes the XOR of all 8 codeword bits equal to 0.
- R4: The decoder's 3-bit syndrome equals the received check bits XOR the check bits recomputed from the received data. For a single flip at position 1..7 it equals that position. It is 0 for a clean word or a flip of bit 7 alone.
- R5: An unmodified codeword decodes with the ok flag set and the original data.
- R6: A single flip at any of positions 1..7 decodes to the original data with the fixed flag set.
- R7: A flip of the parity bit alone decodes with syndrome 0, the fixed flag set, and the data unchanged.
- R8: Any two flipped bits set the fatal flag. The data output then equals the received data bits, uncorrected.
- R9: While a channel's output valid is high, exactly one of ok, fixed and fatal is set. While it is low, none is set.
- R10: With registered outputs, each channel's output valid equals its input valid one cycle earlier, and the result belongs to that input.
- R11: A synchronous active-high reset clears both output valids and all three flags by the next clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| enc_valid_i | input | 1 | Encode request valid |
| enc_data_i | input | DATA_W (4) | Nibble to encode |
| enc_valid_o | output | 1 | Encoded word valid |
| enc_code_o | output | CODE_W (8) | Encoded codeword |
| dec_valid_i | input | 1 | Decode request valid |
| dec_code_i | input | CODE_W (8) | Codeword to decode |
| dec_valid_o | output | 1 | Decode result valid |
| dec_data_o | output | DATA_W (4) | Corrected data, or raw data on a double error |
| dec_syndrome_o | output | CHK_W (3) | Syndrome |
| dec_ok_o | output | 1 | No error seen |
| dec_fixed_o | output | 1 | Single error corrected |
| dec_fatal_o | output | 1 | Uncorrectable double error |

## Verification
The assertions hold on every cycle:
- the even parity of every emitted codeword;
- the one-hot or all-clear state of the three flags;
- the syndrome being zero on clean reads and nonzero on fatal ones;
- the one-cycle valid latency;
- the clearing of both channels by reset.

Only the bench scenarios can show that the correction lands on the right bit and that the check bits sit at the right positions. Those scenarios are every single flip and every flip pair across all 16 nibbles, compared against codewords and syndromes computed independently. The same holds for the parity-only flip leaving the data untouched and for the raw pass-through on a double error.

// File: rtl/secded_pkg.sv
package secded_pkg;

  typedef enum logic [1:0] {
    ST_CLEAN = 2'd0,
    ST_FIXED = 2'd1,
    ST_FATAL = 2'd2
  } dec_status_e;

  // A codeword position is a check-bit slot when it is a power of two.
  function automatic bit is_pow2(input int p);
    return (p > 0) && ((p & (p - 1)) == 0);
  endfunction

  // Index of the data bit stored at a non-power-of-two position p.
  function automatic int data_index(input int p);
    return p - $clog2(p + 1) - 1;
  endfunction

endpackage

// File: rtl/secded_chk.sv
module secded_chk #(
  parameter int CHK_W = 3,
  localparam int CODE_W = 1 << CHK_W,
  localparam int DATA_W = CODE_W - 1 - CHK_W
) (
  input  logic [DATA_W-1:0] data_i,
  output logic [CHK_W-1:0]  chk_o
);
  import secded_pkg::*;

  // Coverage mask of check bit k over the data vector.
  function automatic logic [DATA_W-1:0] cover_mask(input int k);
    logic [DATA_W-1:0] m;
    m = '0;
    for (int p = 1; p < CODE_W; p++) begin
      if (!is_pow2(p) && (((p >> k) & 1) == 1)) m[data_index(p)] = 1'b1;
    end
    return m;
  endfunction

  for (genvar k = 0; k < CHK_W; k++) begin : g_chk
    localparam logic [DATA_W-1:0] MASK = cover_mask(k);
    assign chk_o[k] = ^(data_i & MASK);
  end

endmodule

// File: rtl/secded_enc.sv
module secded_enc #(
  parameter int CHK_W = 3,
  localparam int CODE_W = 1 << CHK_W,
  localparam int DATA_W = CODE_W - 1 - CHK_W
) (
  input  logic [DATA_W-1:0] data_i,
  output logic [CODE_W-1:0] code_o
);
  import secded_pkg::*;

  logic [CHK_W-1:0]  chk;
  logic [CODE_W-2:0] body;

  secded_chk #(.CHK_W(CHK_W)) u_chk (
    .data_i (data_i),
    .chk_o  (chk)
  );

  // Interleave check bits at power-of-two positions and data elsewhere.
  for (genvar p = 1; p < CODE_W; p++) begin : g_place
    if (is_pow2(p)) begin : g_c
      assign body[p-1] = chk[$clog2(p)];
    end else begin : g_d
      assign body[p-1] = data_i[data_index(p)];
    end
  end

  assign code_o = {^body, body};

endmodule

// File: rtl/secded_dec.sv
module secded_dec #(
  parameter int CHK_W = 3,
  localparam int CODE_W = 1 << CHK_W,
  localparam int DATA_W = CODE_W - 1 - CHK_W
) (
  input  logic [CODE_W-1:0]        code_i,
  output logic [DATA_W-1:0]        data_o,
  output logic [CHK_W-1:0]         syn_o,
  output secded_pkg::dec_status_e  status_o
);
  import secded_pkg::*;

  logic [DATA_W-1:0] raw;
  logic [CHK_W-1:0]  stored;
  logic [CHK_W-1:0]  recomputed;
  logic [DATA_W-1:0] flip;
  logic              par_bad;
  logic              syn_nz;
  logic              fix_en;

  // Split the received word into its data and check fields.
  for (genvar p = 1; p < CODE_W; p++) begin : g_split
    if (is_pow2(p)) begin : g_c
      assign stored[$clog2(p)] = code_i[p-1];
    end else begin : g_d
      assign raw[data_index(p)] = code_i[p-1];
    end
  end

  secded_chk #(.CHK_W(CHK_W)) u_chk (
    .data_i (raw),
    .chk_o  (recomputed)
  );

  assign syn_o   = stored ^ recomputed;
  assign par_bad = ^code_i;
  assign syn_nz  = |syn_o;
  assign fix_en  = syn_nz && par_bad;

  // Only data positions matter for the output; a check-bit hit changes nothing.
  for (genvar p = 1; p < CODE_W; p++) begin : g_flip
    if (!is_pow2(p)) begin : g_d
      assign flip[data_index(p)] = fix_en && (syn_o == CHK_W'(p));
    end
  end

  assign data_o = raw ^ flip;

  always_comb begin
    if (!syn_nz && !par_bad) status_o = ST_CLEAN;
    else if (par_bad)        status_o = ST_FIXED;
    else                     status_o = ST_FATAL;
  end

endmodule

// File: rtl/secded_stage.sv
module secded_stage #(
  parameter int W   = 8,
  parameter bit REG = 1'b1
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         valid_i,
  input  logic [W-1:0] bits_i,
  output logic         valid_o,
  output logic [W-1:0] bits_o
);

  if (REG) begin : g_reg
    logic         v_q;
    logic [W-1:0] b_q;
    always_ff @(posedge clk) begin
      if (rst) begin
        v_q <= 1'b0;
        b_q <= '0;
      end else begin
        v_q <= valid_i;
        if (valid_i) b_q <= bits_i;
      end
    end
    assign valid_o = v_q;
    assign bits_o  = b_q;
  end else begin : g_wire
    assign valid_o = valid_i;
    assign bits_o  = bits_i;
  end

endmodule

// File: rtl/sec_ded_codec.sv
module sec_ded_codec #(
  parameter int CHK_W   = 3,
  parameter bit REG_OUT = 1'b1,
  localparam int CODE_W = 1 << CHK_W,
  localparam int DATA_W = CODE_W - 1 - CHK_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              enc_valid_i,
  input  logic [DATA_W-1:0] enc_data_i,
  output logic              enc_valid_o,
  output logic [CODE_W-1:0] enc_code_o,
  input  logic              dec_valid_i,
  input  logic [CODE_W-1:0] dec_code_i,
  output logic              dec_valid_o,
  output logic [DATA_W-1:0] dec_data_o,
  output logic [CHK_W-1:0]  dec_syndrome_o,
  output logic              dec_ok_o,
  output logic              dec_fixed_o,
  output logic              dec_fatal_o
);
  import secded_pkg::*;

  localparam int DEC_W = DATA_W + CHK_W + 2;

  logic [CODE_W-1:0] enc_code;
  logic [DATA_W-1:0] dec_data;
  logic [CHK_W-1:0]  dec_syn;
  dec_status_e       dec_stat;
  logic [DEC_W-1:0]  dec_bits_q;
  logic [1:0]        stat_q;

  secded_enc #(.CHK_W(CHK_W)) u_enc (
    .data_i (enc_data_i),
    .code_o (enc_code)
  );

  secded_dec #(.CHK_W(CHK_W)) u_dec (
    .code_i   (dec_code_i),
    .data_o   (dec_data),
    .syn_o    (dec_syn),
    .status_o (dec_stat)
  );

  secded_stage #(.W(CODE_W), .REG(REG_OUT)) u_enc_stage (
    .clk     (clk),
    .rst     (rst),
    .valid_i (enc_valid_i),
    .bits_i  (enc_code),
    .valid_o (enc_valid_o),
    .bits_o  (enc_code_o)
  );

  secded_stage #(.W(DEC_W), .REG(REG_OUT)) u_dec_stage (
    .clk     (clk),
    .rst     (rst),
    .valid_i (dec_valid_i),
    .bits_i  ({dec_data, dec_syn, dec_stat}),
    .valid_o (dec_valid_o),
    .bits_o  (dec_bits_q)
  );

  assign {dec_data_o, dec_syndrome_o, stat_q} = dec_bits_q;

  assign dec_ok_o    = dec_valid_o && (stat_q == ST_CLEAN);
  assign dec_fixed_o = dec_valid_o && (stat_q == ST_FIXED);
  assign dec_fatal_o = dec_valid_o && (stat_q == ST_FATAL);

endmodule

// File: rtl/sec_ded_codec_checker.sv
module sec_ded_codec_checker #(
  parameter int CHK_W   = 3,
  parameter bit REG_OUT = 1'b1,
  localparam int CODE_W = 1 << CHK_W
) (
  input logic              clk,
  input logic              rst,
  input logic              enc_valid_i,
  input logic              enc_valid_o,
  input logic [CODE_W-1:0] enc_code_o,
  input logic              dec_valid_i,
  input logic              dec_valid_o,
  input logic [CHK_W-1:0]  dec_syndrome_o,
  input logic              dec_ok_o,
  input logic              dec_fixed_o,
  input logic              dec_fatal_o
);

  p_even_parity_r3: assert property (@(posedge clk) disable iff (rst)
    enc_valid_o |-> ((^enc_code_o) == 1'b0));

  p_flags_onehot_r9: assert property (@(posedge clk) disable iff (rst)
    dec_valid_o |-> ($countones({dec_ok_o, dec_fixed_o, dec_fatal_o}) == 1));

  p_flags_idle_r9: assert property (@(posedge clk) disable iff (rst)
    !dec_valid_o |-> ({dec_ok_o, dec_fixed_o, dec_fatal_o} == 3'b000));

  p_clean_syn_zero_r4: assert property (@(posedge clk) disable iff (rst)
    (dec_valid_o && dec_ok_o) |-> (dec_syndrome_o == '0));

  p_fatal_syn_nonzero_r8: assert property (@(posedge clk) disable iff (rst)
    (dec_valid_o && dec_fatal_o) |-> (dec_syndrome_o != '0));

  if (REG_OUT) begin : g_reg
    p_dec_latency_r10: assert property (@(posedge clk) disable iff (rst)
      dec_valid_i |=> dec_valid_o);
    p_dec_idle_r10: assert property (@(posedge clk) disable iff (rst)
      !dec_valid_i |=> !dec_valid_o);
    p_enc_latency_r10: assert property (@(posedge clk) disable iff (rst)
      enc_valid_i |=> enc_valid_o);
    p_enc_idle_r10: assert property (@(posedge clk) disable iff (rst)
      !enc_valid_i |=> !enc_valid_o);
    p_reset_clear_r11: assert property (@(posedge clk)
      rst |=> (!enc_valid_o && !dec_valid_o));
  end else begin : g_wire
    p_dec_pass_r10: assert property (@(posedge clk) disable iff (rst)
      dec_valid_i == dec_valid_o);
    p_enc_pass_r10: assert property (@(posedge clk) disable iff (rst)
      enc_valid_i == enc_valid_o);
  end

endmodule

bind sec_ded_codec sec_ded_codec_checker #(.CHK_W(CHK_W), .REG_OUT(REG_OUT)) u_checker (
  .clk            (clk),
  .rst            (rst),
  .enc_valid_i    (enc_valid_i),
  .enc_valid_o    (enc_valid_o),
  .enc_code_o     (enc_code_o),
  .dec_valid_i    (dec_valid_i),
  .dec_valid_o    (dec_valid_o),
  .dec_syndrome_o (dec_syndrome_o),
  .dec_ok_o       (dec_ok_o),
  .dec_fixed_o    (dec_fixed_o),
  .dec_fatal_o    (dec_fatal_o)
);

// File: tb/sec_ded_codec_bench.sv
module sec_ded_codec_bench;

  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       enc_valid_i = 1'b0;
  logic [3:0] enc_data_i = '0;
  logic       enc_valid_o;
  logic [7:0] enc_code_o;
  logic       dec_valid_i = 1'b0;
  logic [7:0] dec_code_i = '0;
  logic       dec_valid_o;
  logic [3:0] dec_data_o;
  logic [2:0] dec_syndrome_o;
  logic       dec_ok_o;
  logic       dec_fixed_o;
  logic       dec_fatal_o;

  int vectors = 0;
  int miscompares = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  sec_ded_codec u_sec_ded_codec (
    .clk            (clk),
    .rst            (rst),
    .enc_valid_i    (enc_valid_i),
    .enc_data_i     (enc_data_i),
    .enc_valid_o    (enc_valid_o),
    .enc_code_o     (enc_code_o),
    .dec_valid_i    (dec_valid_i),
    .dec_code_i     (dec_code_i),
    .dec_valid_o    (dec_valid_o),
    .dec_data_o     (dec_data_o),
    .dec_syndrome_o (dec_syndrome_o),
    .dec_ok_o       (dec_ok_o),
    .dec_fixed_o    (dec_fixed_o),
    .dec_fatal_o    (dec_fatal_o)
  );

  // Hand-derived vectors: {nibble, codeword} per R1/R2/R3.
  localparam logic [11:0] VEC [8] = '{
    {4'h0, 8'h00}, {4'h1, 8'h87}, {4'h2, 8'h99}, {4'h4, 8'hAA},
    {4'h8, 8'h4B}, {4'hF, 8'hFF}, {4'h3, 8'h1E}, {4'h5, 8'h2D}
  };

  function automatic logic [7:0] ref_enc(input logic [3:0] d);
    logic [7:0] w;
    w[0] = d[0] ^ d[1] ^ d[3];
    w[1] = d[0] ^ d[2] ^ d[3];
    w[2] = d[0];
    w[3] = d[1] ^ d[2] ^ d[3];
    w[4] = d[1];
    w[5] = d[2];
    w[6] = d[3];
    w[7] = ^w[6:0];
    return w;
  endfunction

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    vectors++;
    if (act !== exp) begin
      miscompares++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  // Drive at a negedge, sample a quarter period after the capturing edge.
  task automatic dec_expect(input logic [7:0] cw, input logic [3:0] exp_d,
                            input logic [2:0] exp_syn, input logic [2:0] exp_flags,
                            input string tag);
    dec_code_i  = cw;
    dec_valid_i = 1'b1;
    @(posedge clk);
    #(CLK_PERIOD/4);
    check({tag, " valid (R10)"}, 32'(dec_valid_o), 32'd1);
    check({tag, " data"}, 32'(dec_data_o), 32'(exp_d));
    check({tag, " syndrome (R4)"}, 32'(dec_syndrome_o), 32'(exp_syn));
    check({tag, " flags ok/fixed/fatal (R9)"}, 32'({dec_ok_o, dec_fixed_o, dec_fatal_o}), 32'(exp_flags));
    @(negedge clk);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    vectors++;
    miscompares++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R11: reset state
    check("R11 enc_valid_o after reset", 32'(enc_valid_o), 32'd0);
    check("R11 dec_valid_o after reset", 32'(dec_valid_o), 32'd0);
    check("R11 flags after reset", 32'({dec_ok_o, dec_fixed_o, dec_fatal_o}), 32'd0);
    rst = 1'b0;
    @(negedge clk);

    // Table walk: encode and clean decode (R1, R2, R3, R5)
    for (int i = 0; i < 8; i++) begin
      enc_data_i  = VEC[i][11:8];
      enc_valid_i = 1'b1;
      dec_expect(VEC[i][7:0], VEC[i][11:8], 3'd0, 3'b100, "R5 table clean");
      check("R1/R2 codeword vs table", 32'(enc_code_o), 32'(VEC[i][7:0]));
      check("R3 codeword even parity", 32'(^enc_code_o), 32'd0);
      check("R10 enc_valid_o", 32'(enc_valid_o), 32'd1);
    end
    enc_valid_i = 1'b0;

    // Exhaustive: all nibbles, clean / single / double flips
    for (int d = 0; d < 16; d++) begin
      logic [7:0] cw;
      cw = ref_enc(4'(d));
      enc_data_i  = 4'(d);
      enc_valid_i = 1'b1;
      dec_expect(cw, 4'(d), 3'd0, 3'b100, "R5 clean");
      check("R1/R2 codeword vs reference", 32'(enc_code_o), 32'(cw));
      enc_valid_i = 1'b0;
      for (int i = 0; i < 8; i++) begin
        if (i < 7) dec_expect(cw ^ (8'h01 << i), 4'(d), 3'(i + 1), 3'b010, "R6 single flip");
        else       dec_expect(cw ^ 8'h80, 4'(d), 3'd0, 3'b010, "R7 parity-only flip");
      end
      for (int i = 0; i < 8; i++) begin
        for (int j = i + 1; j < 8; j++) begin
          logic [7:0] bad;
          logic [2:0] s;
          bad = cw ^ (8'h01 << i) ^ (8'h01 << j);
          s = ((i < 7) ? 3'(i + 1) : 3'd0) ^ ((j < 7) ? 3'(j + 1) : 3'd0);
          dec_expect(bad, {bad[6], bad[5], bad[4], bad[2]}, s, 3'b001, "R8 double flip");
        end
      end
    end

    // R10 / R9: latency and idle behaviour
    dec_valid_i = 1'b0;
    @(negedge clk);
    dec_code_i  = ref_enc(4'hA);
    dec_valid_i = 1'b1;
    #1;
    check("R10 valid not yet visible before edge", 32'(dec_valid_o), 32'd0);
    @(posedge clk);
    #(CLK_PERIOD/4);
    check("R10 valid one cycle later", 32'(dec_valid_o), 32'd1);
    check("R10 data one cycle later", 32'(dec_data_o), 32'hA);
    @(negedge clk);
    dec_valid_i = 1'b0;
    @(posedge clk);
    #(CLK_PERIOD/4);
    check("R10 valid drops after idle input", 32'(dec_valid_o), 32'd0);
    check("R9 no flags while idle", 32'({dec_ok_o, dec_fixed_o, dec_fatal_o}), 32'd0);
    @(negedge clk);

    // R11: reset mid-traffic
    dec_code_i  = ref_enc(4'h6) ^ 8'h03;
    dec_valid_i = 1'b1;
    enc_valid_i = 1'b1;
    rst = 1'b1;
    @(posedge clk);
    #(CLK_PERIOD/4);
    check("R11 dec_valid_o under reset", 32'(dec_valid_o), 32'd0);
    check("R11 enc_valid_o under reset", 32'(enc_valid_o), 32'd0);
    check("R11 flags under reset", 32'({dec_ok_o, dec_fixed_o, dec_fatal_o}), 32'd0);
    @(negedge clk);
    rst = 1'b0;
    dec_valid_i = 1'b0;
    enc_valid_i = 1'b0;
    repeat (2) @(negedge clk);

    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

endmodule